// File: doc/BRIEF.md
# Keyed Watchdog Timer with Scaled Compare

A register-mapped watchdog counter that advances on a slow tick enable and raises an interrupt when a selectable 16-bit window of the count reaches a programmed compare value. Software reaches it through a simple 32-bit port: address, write enable, write data and combinational read data. It can be used either as a watchdog or as a periodic interrupt source.

Every write except a write to the key location needs a fresh unlock. The unlock is a single magic word written to the key location. The next write of any kind uses up that unlock, whether or not the write has an effect. The interrupt-pending flag stays set until software clears it. A reset-request output follows that flag when resets are enabled.

A watchdog feed is an unlocked write of a second magic word to the feed location, which zeroes the count. When zero-on-match is set, each compare hit also zeroes the count, so the timer runs periodically.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is locked, config and count read 0, compare reads 0x0000FFFF, and irq_o and rst_req_o are low.
- R2: A write of 0x0051F15E to offset 0x1C unlocks the timer. Offset 0x1C then reads 1. The next write to any offset locks it again, and offset 0x1C then reads 0.
- R3: While locked, writes to offsets 0x00, 0x08, 0x18 and 0x20 change nothing. A write of any other value to offset 0x1C leaves the timer locked.
- R4: An unlocked write of 0x0D09F00D to offset 0x18 zeroes the count. Any other value written there leaves the count alone but still uses up the unlock. Offset 0x18 always reads 0.
- R5: The count at offset 0x08 is 31 bits wide. Writing 0xAAAAAAAA reads back as 0x2AAAAAAA.
- R6: Config at offset 0x00 holds all 32 written bits, so all ones and zero both read back unchanged. Its fields are: scale in bits 3:0, reset enable in bit 8, zero-on-match in bit 9, run-always in bit 12, run-while-awake in bit 13, and pending in bit 28.
- R7: Offset 0x10 reads bits [scale+15:scale] of the count, zero-extended.
- R8: The count rises by one on each clock with tick_i high, while run-always is set or run-while-awake is set with core_awake_i high. Otherwise it holds, and counting resumes from the held value.
- R9: When the scaled count is at or above compare[15:0] on a clock edge, the pending bit (config bit 28, irq_o) is set by that edge.
- R10: With zero-on-match set, the same edge that sets the pending bit zeroes the count.
- R11: Pending stays set through other writes. Only an unlocked config write with bit 28 at 0 clears it. A compare hit on that same edge wins.
- R12: rst_req_o is high while pending and reset enable are both set.
- R13: Reads of offsets 0x04, 0x0C, 0x14, 0x24 and up return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow-tick count enable |
| core_awake_i | input | 1 | Core awake qualifier for run-while-awake |
| addr_i | input | 6 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt pending |
| rst_req_o | output | 1 | Reset request |

## Verification
Reads are combinational, so a register written on one edge shows its new value at the following falling edge, and the bench samples there. A tick held high across N edges adds exactly N to the count. A compare hit shows on irq_o and rst_req_o one edge after the count reaches the compare value. In zero-on-match mode the count returns to 0 on that same later edge. The directed tasks therefore sample after exactly N tick edges to show that pending is still low, and then after one more edge to show it set.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
  localparam logic [5:0]  OFF_CFG  = 6'h00;
  localparam logic [5:0]  OFF_CNT  = 6'h08;
  localparam logic [5:0]  OFF_SCL  = 6'h10;
  localparam logic [5:0]  OFF_FEED = 6'h18;
  localparam logic [5:0]  OFF_KEY  = 6'h1C;
  localparam logic [5:0]  OFF_CMP  = 6'h20;
  localparam logic [31:0] UNLOCK_WORD = 32'h0051_F15E;
  localparam logic [31:0] FEED_WORD   = 32'h0D09_F00D;
  localparam int unsigned CFG_SCALE_LSB = 0;
  localparam int unsigned CFG_RSTEN     = 8;
  localparam int unsigned CFG_ZERO      = 9;
  localparam int unsigned CFG_ALWAYS    = 12;
  localparam int unsigned CFG_AWAKE     = 13;
  localparam int unsigned CFG_IP        = 28;
endpackage

// File: rtl/kwdt_lock.sv
`timescale 1ns/1ps
module kwdt_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic key_match_i,
  output logic unlocked_o
);
  // every write re-arms or drops the single-use unlock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   unlocked_o <= 1'b0;
    else if (wr_i) unlocked_o <= key_match_i;
  end

  a_r2_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !key_match_i |=> !unlocked_o);
  a_r2_key_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && key_match_i |=> unlocked_o);
  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(unlocked_o));
endmodule

// File: rtl/kwdt_counter.sv
`timescale 1ns/1ps
module kwdt_counter #(
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned SCALE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   load_val_i,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [WIN_W-1:0]   scaled_o
);
  logic [CNT_W-1:0] shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  always_comb begin
    shifted  = cnt_o >> scale_i;
    scaled_o = shifted[WIN_W-1:0];
  end

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !clr_i && !inc_i |=> $stable(cnt_o));
  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i && !clr_i |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !load_i |=> cnt_o == '0);
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned SCALE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              core_awake_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_SCL  = ADDR_W'(OFF_SCL);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(OFF_FEED);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFF_CMP);

  logic sel_cfg, sel_cnt, sel_feed, sel_key, sel_cmp;
  logic unlocked, wr_ok, feed_ok, run, inc, hit;
  logic [DATA_W-1:0] cfg_q;
  logic [WIN_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  cnt;
  logic [WIN_W-1:0]  scaled;

  assign sel_cfg  = addr_i == A_CFG;
  assign sel_cnt  = addr_i == A_CNT;
  assign sel_feed = addr_i == A_FEED;
  assign sel_key  = addr_i == A_KEY;
  assign sel_cmp  = addr_i == A_CMP;

  kwdt_lock u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (we_i),
    .key_match_i (sel_key && wdata_i == DATA_W'(UNLOCK_WORD)),
    .unlocked_o  (unlocked)
  );

  assign wr_ok   = we_i && unlocked && !sel_key;
  assign feed_ok = wr_ok && sel_feed && wdata_i == DATA_W'(FEED_WORD);
  assign run     = cfg_q[CFG_ALWAYS] || (cfg_q[CFG_AWAKE] && core_awake_i);
  assign inc     = tick_i && run;
  assign hit     = scaled >= cmp_q;

  kwdt_counter #(.CNT_W(CNT_W), .WIN_W(WIN_W), .SCALE_W(SCALE_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_ok && sel_cnt),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .clr_i      (feed_ok || (hit && cfg_q[CFG_ZERO])),
    .inc_i      (inc),
    .scale_i    (cfg_q[CFG_SCALE_LSB +: SCALE_W]),
    .cnt_o      (cnt),
    .scaled_o   (scaled)
  );

  // hardware set of pending overrides a same-edge software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cmp_q <= '1;
    end else begin
      if (wr_ok && sel_cfg) cfg_q <= wdata_i;
      if (hit) cfg_q[CFG_IP] <= 1'b1;
      if (wr_ok && sel_cmp) cmp_q <= wdata_i[WIN_W-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      A_CFG:   rdata_o = cfg_q;
      A_CNT:   rdata_o = DATA_W'(cnt);
      A_SCL:   rdata_o = DATA_W'(scaled);
      A_KEY:   rdata_o = DATA_W'(unlocked);
      A_CMP:   rdata_o = DATA_W'(cmp_q);
      default: rdata_o = '0;
    endcase
  end

  assign irq_o     = cfg_q[CFG_IP];
  assign rst_req_o = cfg_q[CFG_IP] && cfg_q[CFG_RSTEN];

  a_r3_locked_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !unlocked |=> $stable(cmp_q));
  a_r3_locked_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !unlocked && !inc && !hit |=> $stable(cnt));
  a_r9_hit_sets_ip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> irq_o);
  a_r11_ip_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(wr_ok && sel_cfg && !wdata_i[CFG_IP]) |=> irq_o);
  a_r12_rst_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && cfg_q[CFG_RSTEN] && !(wr_ok && sel_cfg) |=> rst_req_o);
  a_r10_zero_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && cfg_q[CFG_ZERO] && !(wr_ok && sel_cnt) |=> cnt == '0);
endmodule

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
  localparam logic [5:0]  CFG = 6'h00, CNT = 6'h08, SCL = 6'h10, FEED = 6'h18, KEY = 6'h1C, CMP = 6'h20;
  localparam logic [31:0] UNL = 32'h0051F15E, FW = 32'h0D09F00D;
  localparam logic [31:0] B_RSTEN = 32'h100, B_ZERO = 32'h200, B_ALW = 32'h1000, B_AWK = 32'h2000, B_IP = 32'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, awake = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rreq;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  keyed_wdt dut (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .core_awake_i(awake),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rreq));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic uwr(logic [5:0] a, logic [31:0] d);
    wr(KEY, UNL);
    wr(a, d);
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic init();
    awake = 1'b0;
    uwr(CMP, 32'hFFFF); uwr(CNT, 0); uwr(CFG, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(KEY, v); check("R1 key", v, 0);
    rd(CFG, v); check("R1 cfg", v, 0);
    rd(CNT, v); check("R1 cnt", v, 0);
    rd(CMP, v); check("R1 cmp", v, 32'hFFFF);
    check("R1 irq/rreq", {30'd0, irq, rreq}, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(CNT, 32'hBEEF); rd(CNT, v); check("R3 locked cnt", v, 0);
    wr(CMP, 32'h1234); rd(CMP, v); check("R3 locked cmp", v, 32'hFFFF);
    wr(CFG, 32'h3); rd(CFG, v); check("R3 locked cfg", v, 0);
    wr(KEY, 32'hFFFF); rd(KEY, v); check("R3 bad key", v, 0);
    wr(KEY, UNL); rd(KEY, v); check("R2 key open", v, 1);
    wr(CNT, 32'hBEEF); rd(CNT, v); check("R2 cnt write", v, 32'hBEEF);
    rd(KEY, v); check("R2 relocked", v, 0);
    wr(CNT, 32'h5); rd(CNT, v); check("R2 one shot", v, 32'hBEEF);
    uwr(CMP, 32'hBEEF); rd(CMP, v); check("R2 cmp write", v, 32'hBEEF);
  endtask

  task automatic t_feed_width();
    logic [31:0] v;
    init();
    uwr(CNT, 32'hAAAAAAAA); rd(CNT, v); check("R5 width", v, 32'h2AAAAAAA);
    uwr(FEED, 32'hAAAAAAAA); rd(CNT, v); check("R4 bad feed", v, 32'h2AAAAAAA);
    rd(KEY, v); check("R4 bad feed consumes", v, 0);
    wr(FEED, FW); rd(CNT, v); check("R4 locked feed", v, 32'h2AAAAAAA);
    uwr(FEED, FW); rd(CNT, v); check("R4 feed clears", v, 0);
    rd(FEED, v); check("R4 feed reads 0", v, 0);
    rd(6'h04, v); check("R13 unmapped 04", v, 0);
    rd(6'h3C, v); check("R13 unmapped 3C", v, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    init();
    uwr(CFG, 32'hFFFFFFFF); rd(CFG, v); check("R6 all ones", v, 32'hFFFFFFFF);
    uwr(CFG, 0); rd(CFG, v); check("R6 zero", v, 0);
  endtask

  task automatic t_scaled();
    logic [31:0] v;
    init();
    uwr(CNT, 32'h12345678); rd(CNT, v); check("R7 cnt", v, 32'h12345678);
    for (int s = 0; s < 16; s++) begin
      uwr(CFG, 32'(s)); rd(SCL, v);
      check("R7 scaled", v, (32'h12345678 >> s) & 32'hFFFF);
    end
  endtask

  task automatic t_enable();
    logic [31:0] v;
    init();
    uwr(CFG, B_ALW); ticks(7); rd(CNT, v); check("R8 run", v, 7);
    repeat (3) @(negedge clk); rd(CNT, v); check("R8 no tick", v, 7);
    uwr(CFG, 0); ticks(5); rd(CNT, v); check("R8 hold", v, 7);
    uwr(CFG, B_ALW); ticks(3); rd(CNT, v); check("R8 resume", v, 10);
    uwr(CFG, B_AWK); ticks(4); rd(CNT, v); check("R8 asleep", v, 10);
    awake = 1'b1; ticks(4); rd(CNT, v); check("R8 awake", v, 14);
    awake = 1'b0;
  endtask

  task automatic t_compare();
    logic [31:0] v;
    init();
    uwr(CMP, 5); uwr(CFG, B_ALW);
    ticks(5); check("R9 not yet", {31'd0, irq}, 0);
    rd(CNT, v); check("R9 cnt at cmp", v, 5);
    @(negedge clk); check("R9 irq", {31'd0, irq}, 1);
    rd(CFG, v); check("R9 cfg ip", v, B_ALW | B_IP);
    check("R12 no rsten", {31'd0, rreq}, 0);
    wr(CFG, 0); check("R11 locked clr", {31'd0, irq}, 1);
    uwr(CNT, 0); check("R11 sticky", {31'd0, irq}, 1);
    uwr(CFG, B_ALW); check("R11 cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    init();
    uwr(CMP, 3); uwr(CFG, B_ALW | B_ZERO);
    ticks(3); rd(CNT, v); check("R10 cnt 3", v, 3);
    check("R10 irq 0", {31'd0, irq}, 0);
    ticks(1); rd(CNT, v); check("R10 cleared", v, 0);
    check("R10 irq", {31'd0, irq}, 1);
    uwr(CFG, B_ALW | B_ZERO); check("R11 clr", {31'd0, irq}, 0);
    ticks(4); rd(CNT, v); check("R10 period 2", v, 0);
    check("R10 irq again", {31'd0, irq}, 1);
  endtask

  task automatic t_rstreq();
    init();
    uwr(CMP, 2); uwr(CFG, B_ALW | B_RSTEN);
    ticks(2); check("R12 pre", {31'd0, rreq}, 0);
    @(negedge clk); check("R12 req", {31'd0, rreq}, 1);
    uwr(CNT, 0); uwr(CFG, 0); check("R12 drop", {31'd0, rreq}, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_feed_width();
    t_cfg();
    t_scaled();
    t_enable();
    t_compare();
    t_periodic();
    t_rstreq();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule